// File: doc/BRIEF.md
# Paced Bulk Transfer Sequencer

This block drives one bulk data movement across a byte-wide mailbox channel to a remote processor. A command carries a 3-bit reason code, followed by a 32-bit remote address delivered as four byte beats, least significant byte first. Once the address is complete, the sequencer emits byte-access strobes toward the local side of the mailbox. The strobes are paced in microsecond ticks, so that the FIFO on the far side has time to drain or refill between accesses. Data itself is not carried here: each strobe stands for one byte moved, and a running byte count is exported.

The reason code selects the direction, the granule, the start-up wait and the spacing:

- Reasons 0 and 1 move single bytes.
- Reasons 2 and 3 move byte pairs.
- Reasons 6 and 7 move a fixed 256-byte block.
- Reason 4 launches execution at the remote address.
- Reason 5 is refused.

In the open-ended modes (0 to 3), a stop input ends the transfer. The block modes end by themselves.

The command and address inputs follow valid/ready rules. A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while no transfer is in progress, and a held `cmd_valid` is simply left waiting. An address byte is taken only when `addr_valid` and `addr_ready` are both high. `addr_ready` is high only during the address phase that follows an accepted command, so any byte offered at another time stays pending.

Top module: `xfer_pacer`

## Requirements
- R1: After an accepted command (other than reason 5), `addr_ready` goes high. Four accepted address bytes are assembled least significant first, so the first byte accepted lands in `remote_addr[7:0]` and the fourth in `remote_addr[31:24]`. `addr_ready` is low at all other times.
- R2: Reason 0 (even code, so a read) raises `rd_stb` only. It waits 24 ticks before the first access and 24 ticks between accesses.
- R3: Reason 1 (odd code, so a write) raises `wr_stb` only. The first access follows the last address byte with no tick wait. Later accesses are spaced 24 ticks apart.
- R4: Reasons 2 (read) and 3 (write) issue each access as two strobes in consecutive cycles. Reason 2 waits 26 ticks before the first pair and reason 3 waits none. Both wait 26 ticks between pairs.
- R5: Reason 6 (read) waits 19 ticks and reason 7 (write) waits none before the first byte. Both space bytes 10 ticks apart. `done` pulses in the cycle after the 256th strobe, and `byte_cnt` then reads 256.
- R6: Reason 4 produces a one-cycle `exec_pulse` in the cycle after the fourth address byte. It produces no strobe, and `cmd_ready` is high again in that same cycle.
- R7: Reason 5 produces a one-cycle `err_pulse` in the cycle after acceptance. It has no address phase and produces no strobe.
- R8: In reasons 0 to 3, `stop` is taken while `gap` is high. `done` then pulses, `cmd_ready` returns high in the same cycle, and no further strobe follows. In reasons 6 and 7, `stop` has no effect.
- R9: While a transfer is in progress, `cmd_ready` is low and `cmd_valid` has no effect; in particular, no `err_pulse` appears.
- R10: `gap` is high exactly while the sequencer waits for ticks. The number of `us_tick` pulses seen with `gap` high before each access equals the wait that R2 to R5 give for that access.
- R11: During and after reset, `cmd_ready` is 1 and every other output is 0.
- R12: `byte_cnt` starts at 0 for each transfer and rises by one after every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_reason | input | 3 | Reason code |
| addr_valid | input | 1 | Address byte offered |
| addr_ready | output | 1 | Address byte can be taken |
| addr_byte | input | 8 | Address byte, least significant first |
| stop | input | 1 | End an open-ended transfer |
| rd_stb | output | 1 | One byte read from the remote side |
| wr_stb | output | 1 | One byte written to the remote side |
| gap | output | 1 | Waiting for pacing ticks |
| byte_cnt | output | 9 | Bytes moved in this transfer |
| remote_addr | output | 32 | Assembled remote address |
| done | output | 1 | Transfer finished (one cycle) |
| exec_pulse | output | 1 | Execute launched (one cycle) |
| err_pulse | output | 1 | Reserved reason refused (one cycle) |

## Verification
A wrong pacing count, either in the loaded value or in the decrement, shows up at the very next strobe as a tick tally that differs from the table. A missing or extra second byte in a pair shows up at once as a lone strobe or a third one. A corrupted byte counter appears in `byte_cnt` on the following strobe. In block modes it also appears as `done` arriving at the wrong point, at the latest after 256 strobes. A wrong mode latch is visible from the first strobe as the wrong direction, or from the cycle after the address as a missing `exec_pulse`.

// File: rtl/xfer_pacer_pkg.sv
package xfer_pacer_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WAIT,
    S_ACC1,
    S_ACC2
  } seq_state_t;

  typedef struct packed {
    logic is_read;
    logic is_pair;
    logic is_block;
    logic is_exec;
  } xfer_mode_t;

  function automatic xfer_mode_t decode_reason(input logic [2:0] r);
    xfer_mode_t m;
    m.is_read  = ~r[0];
    m.is_pair  = (r == 3'd2) || (r == 3'd3);
    m.is_block = (r == 3'd6) || (r == 3'd7);
    m.is_exec  = (r == 3'd4);
    return m;
  endfunction

  function automatic logic is_reserved(input logic [2:0] r);
    return r == 3'd5;
  endfunction

endpackage

// File: rtl/pace_table.sv
module pace_table
  import xfer_pacer_pkg::*;
#(
  parameter int TW         = 8,
  parameter int T_SINGLE   = 24,
  parameter int T_PAIR     = 26,
  parameter int T_BLK_INIT = 19,
  parameter int T_BLK      = 10
) (
  input  logic [2:0]    reason,
  output xfer_mode_t    mode,
  output logic [TW-1:0] init_ticks,
  output logic [TW-1:0] step_ticks
);

  always_comb begin
    mode = decode_reason(reason);
    init_ticks = '0;
    step_ticks = TW'(T_SINGLE);
    case (reason)
      3'd0: init_ticks = TW'(T_SINGLE);
      3'd2: begin init_ticks = TW'(T_PAIR); step_ticks = TW'(T_PAIR); end
      3'd3: step_ticks = TW'(T_PAIR);
      3'd6: begin init_ticks = TW'(T_BLK_INIT); step_ticks = TW'(T_BLK); end
      3'd7: step_ticks = TW'(T_BLK);
      default: ;
    endcase
  end

endmodule

// File: rtl/addr_collector.sv
module addr_collector #(
  parameter int NBYTES = 4,
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int AW = 8 * NBYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift,
  input  logic [7:0]    byte_in,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [IW-1:0] idx;

  assign last = (idx == IW'(NBYTES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      idx  <= '0;
    end else if (shift) begin
      addr <= {byte_in, addr[AW-1:8]};
      idx  <= last ? '0 : idx + 1'b1;
    end
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          run,
  input  logic          tick,
  output logic          expire
);

  logic [TW-1:0] cnt;

  assign expire = run && tick && (cnt == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (load)                       cnt <= load_val;
    else if (run && tick && cnt > TW'(1)) cnt <= cnt - 1'b1;
  end

  assert_cnt_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt != '0));

endmodule

// File: rtl/xfer_pacer.sv
module xfer_pacer
  import xfer_pacer_pkg::*;
#(
  parameter int ADDR_BYTES = 4,
  parameter int BLOCK_LEN  = 256,
  parameter int TW         = 8,
  parameter int T_SINGLE   = 24,
  parameter int T_PAIR     = 26,
  parameter int T_BLK_INIT = 19,
  parameter int T_BLK      = 10,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int CW = $clog2(BLOCK_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          us_tick,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_reason,
  input  logic          addr_valid,
  output logic          addr_ready,
  input  logic [7:0]    addr_byte,
  input  logic          stop,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          gap,
  output logic [CW-1:0] byte_cnt,
  output logic [AW-1:0] remote_addr,
  output logic          done,
  output logic          exec_pulse,
  output logic          err_pulse
);

  seq_state_t    state;
  logic [2:0]    reason_q;
  xfer_mode_t    mode;
  logic [TW-1:0] init_ticks, step_ticks;
  logic          addr_last, expire;
  logic          addr_fire, addr_done, access, acc_end, blk_last, stop_hit;
  logic          t_load;
  logic [TW-1:0] t_val;

  pace_table #(.TW(TW), .T_SINGLE(T_SINGLE), .T_PAIR(T_PAIR),
               .T_BLK_INIT(T_BLK_INIT), .T_BLK(T_BLK)) u_table (
    .reason(reason_q), .mode(mode),
    .init_ticks(init_ticks), .step_ticks(step_ticks));

  addr_collector #(.NBYTES(ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .shift(addr_fire), .byte_in(addr_byte),
    .addr(remote_addr), .last(addr_last));

  tick_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val),
    .run(gap), .tick(us_tick), .expire(expire));

  assign cmd_ready  = (state == S_IDLE);
  assign addr_ready = (state == S_ADDR);
  assign gap        = (state == S_WAIT);
  assign access     = (state == S_ACC1) || (state == S_ACC2);
  assign rd_stb     = access && mode.is_read;
  assign wr_stb     = access && !mode.is_read;

  assign addr_fire = addr_ready && addr_valid;
  assign addr_done = addr_fire && addr_last;
  assign acc_end   = ((state == S_ACC1) && !mode.is_pair) || (state == S_ACC2);
  assign blk_last  = mode.is_block && (byte_cnt == CW'(BLOCK_LEN - 1));
  assign stop_hit  = gap && stop && !mode.is_block;
  assign t_load    = (addr_done && !mode.is_exec && init_ticks != '0) ||
                     (acc_end && !blk_last);
  assign t_val     = acc_end ? step_ticks : init_ticks;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      reason_q   <= '0;
      byte_cnt   <= '0;
      done       <= 1'b0;
      exec_pulse <= 1'b0;
      err_pulse  <= 1'b0;
    end else begin
      done       <= 1'b0;
      exec_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      if (access) byte_cnt <= byte_cnt + 1'b1;
      case (state)
        S_IDLE: if (cmd_valid) begin
          if (is_reserved(cmd_reason)) begin
            err_pulse <= 1'b1;
          end else begin
            reason_q <= cmd_reason;
            byte_cnt <= '0;
            state    <= S_ADDR;
          end
        end
        S_ADDR: if (addr_done) begin
          if (mode.is_exec) begin
            exec_pulse <= 1'b1;
            state      <= S_IDLE;
          end else if (init_ticks == '0) begin
            state <= S_ACC1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (stop_hit) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (expire) begin
            state <= S_ACC1;
          end
        end
        S_ACC1, S_ACC2: begin
          if (!acc_end) begin
            state <= S_ACC2;
          end else if (blk_last) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_one_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb, wr_stb}));

  assert_pair_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == S_ACC1) && mode.is_pair) |=> (rd_stb || wr_stb));

  assert_block_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode.is_block) |-> (byte_cnt == CW'(BLOCK_LEN)));

  assert_exec_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pulse |-> (cmd_ready && !rd_stb && !wr_stb && byte_cnt == '0));

  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(cmd_valid && cmd_ready) && cmd_ready && !addr_ready));

  assert_stop_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && stop && !mode.is_block) |=> (done && cmd_ready));

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_ready && cmd_valid) |=> ($stable(reason_q) && !err_pulse));

endmodule

// File: tb/sim_xfer_pacer.sv
`timescale 1ns/1ps
module sim_xfer_pacer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_reason = '0;
  logic        addr_valid = 1'b0;
  logic        addr_ready;
  logic [7:0]  addr_byte = '0;
  logic        stop = 1'b0;
  logic        rd_stb, wr_stb, gap;
  logic [8:0]  byte_cnt;
  logic [31:0] remote_addr;
  logic        done, exec_pulse, err_pulse;

  int total = 0;
  int bad = 0;

  // monitor state
  bit         mon_on = 1'b0;
  logic [2:0] mon_reason = '0;
  bit         mon_first = 1'b0;
  bit         pend2 = 1'b0;
  bit         prev_stb = 1'b0;
  int         gapticks = 0;
  int         nbytes = 0;

  always #2.5 clk = ~clk;

  xfer_pacer u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_reason(cmd_reason),
    .addr_valid(addr_valid), .addr_ready(addr_ready), .addr_byte(addr_byte),
    .stop(stop), .rd_stb(rd_stb), .wr_stb(wr_stb), .gap(gap),
    .byte_cnt(byte_cnt), .remote_addr(remote_addr), .done(done),
    .exec_pulse(exec_pulse), .err_pulse(err_pulse));

  function automatic int exp_init(input logic [2:0] r);
    case (r)
      3'd0: return 24;
      3'd2: return 26;
      3'd6: return 19;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_step(input logic [2:0] r);
    case (r)
      3'd0, 3'd1: return 24;
      3'd2, 3'd3: return 26;
      default: return 10;
    endcase
  endfunction

  function automatic bit exp_pair(input logic [2:0] r);
    return (r == 3'd2) || (r == 3'd3);
  endfunction

  function automatic string req_of(input logic [2:0] r);
    case (r)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // pacing tick source: one pulse every 4 cycles
  initial begin
    forever begin
      repeat (3) @(posedge clk);
      #1 us_tick = 1'b1;
      @(posedge clk);
      #1 us_tick = 1'b0;
    end
  end

  // strobe monitor, samples on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (!mon_on) begin
        if (rd_stb || wr_stb) check(1'b0, "R7 stray strobe", 1, 0);
      end else begin
        if (us_tick && gap) gapticks++;
        if (rd_stb || wr_stb) begin
          check(rd_stb == !mon_reason[0], {req_of(mon_reason), " direction"},
                rd_stb, !mon_reason[0]);
          check(byte_cnt == 9'(nbytes), "R12 byte_cnt", byte_cnt, nbytes);
          if (pend2) begin
            check(prev_stb && gapticks == 0, "R4 second byte", gapticks, 0);
            pend2 = 1'b0;
          end else begin
            check(gapticks == (mon_first ? exp_init(mon_reason) : exp_step(mon_reason)),
                  {req_of(mon_reason), " R10 tick spacing"}, gapticks,
                  mon_first ? exp_init(mon_reason) : exp_step(mon_reason));
            mon_first = 1'b0;
            gapticks  = 0;
            pend2     = exp_pair(mon_reason);
          end
          nbytes++;
        end
      end
      prev_stb = rd_stb || wr_stb;
    end
  end

  task automatic run_xfer(input logic [2:0] r, input logic [31:0] a,
                          input int n_acc, input bit poke_stop);
    int bpa;
    bpa = exp_pair(r) ? 2 : 1;
    mon_reason = r; mon_first = 1'b1; pend2 = 1'b0; gapticks = 0; nbytes = 0;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    check(addr_ready == 1'b0, "R1 ready low when idle", addr_ready, 0);
    mon_on = (r != 3'd4) && (r != 3'd5);
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_reason = r;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    if (r == 3'd5) begin
      check(err_pulse == 1'b1, "R7 err pulse", err_pulse, 1);
      check(addr_ready == 1'b0 && cmd_ready == 1'b1, "R7 no addr phase", addr_ready, 0);
      @(negedge clk);
      check(err_pulse == 1'b0, "R7 single cycle", err_pulse, 0);
      return;
    end
    check(addr_ready == 1'b1, "R1 addr phase open", addr_ready, 1);
    for (int i = 0; i < 4; i++) begin
      repeat ($urandom % 3) @(posedge clk);
      @(posedge clk); #1 addr_valid = 1'b1; addr_byte = a[8*i +: 8];
      @(posedge clk); #1 addr_valid = 1'b0;
    end
    @(negedge clk);
    check(remote_addr == a, "R1 address assembly", remote_addr, a);
    if (r == 3'd4) begin
      check(exec_pulse == 1'b1 && cmd_ready == 1'b1, "R6 exec pulse", exec_pulse, 1);
      repeat (12) @(negedge clk);
      check(byte_cnt == 9'd0 && exec_pulse == 1'b0, "R6 quiet after exec", byte_cnt, 0);
      return;
    end
    check(exec_pulse == 1'b0, "R6 no exec pulse for transfer", exec_pulse, 0);
    // a command offered while busy must be ignored
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_reason = 3'd5;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!cmd_ready && !err_pulse, "R9 busy ignores command", err_pulse, 0);
    end
    @(posedge clk); #1 cmd_valid = 1'b0;
    if (r[2:1] == 2'b11) begin
      if (poke_stop) begin
        @(negedge clk);
        while (nbytes < 40) @(negedge clk);
        @(posedge clk); #1 stop = 1'b1;
        repeat (30) @(posedge clk);
        #1 stop = 1'b0;
        check(!done && !cmd_ready, "R8 stop ignored in block", cmd_ready, 0);
      end
      @(negedge clk);
      while (!done) @(negedge clk);
      check(nbytes == 256, "R5 block length", nbytes, 256);
      check(byte_cnt == 9'd256, "R5 final count", byte_cnt, 256);
      check(cmd_ready == 1'b1, "R5 idle at done", cmd_ready, 1);
    end else begin
      @(negedge clk);
      while (nbytes < n_acc * bpa) @(negedge clk);
      @(posedge clk); #1 stop = 1'b1;
      @(negedge clk);
      while (!done) @(negedge clk);
      check(cmd_ready == 1'b1, "R8 idle with done", cmd_ready, 1);
      @(posedge clk); #1 stop = 1'b0;
      check(nbytes == n_acc * bpa, "R8 no access after stop", nbytes, n_acc * bpa);
      check(byte_cnt == 9'(n_acc * bpa), "R12 count after stop", byte_cnt, n_acc * bpa);
    end
    mon_on = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b1 && addr_ready == 1'b0 && !rd_stb && !wr_stb,
          "R11 reset outputs", cmd_ready, 1);
    check(byte_cnt == 9'd0 && !done && !err_pulse && !exec_pulse && !gap,
          "R11 reset status", byte_cnt, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && byte_cnt == 9'd0 && remote_addr == 32'd0,
          "R11 after reset", remote_addr, 0);

    run_xfer(3'd5, 32'h0, 0, 1'b0);
    run_xfer(3'd4, 32'h1234_5678, 0, 1'b0);
    run_xfer(3'd0, 32'hA1B2_C3D4, 3, 1'b0);
    run_xfer(3'd1, 32'h0000_00FF, 2, 1'b0);
    run_xfer(3'd2, 32'hFFFF_0001, 2, 1'b0);
    run_xfer(3'd3, 32'h8000_0000, 3, 1'b0);
    run_xfer(3'd6, 32'h0001_2000, 0, 1'b1);
    run_xfer(3'd7, 32'hDEAD_BEEF, 0, 1'b0);
    run_xfer(3'd1, 32'h0, 1, 1'b0);

    for (int t = 0; t < 24; t++) begin
      logic [2:0] r;
      r = 3'($urandom % 6);
      run_xfer(r, $urandom, 1 + int'($urandom % 3), 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule